// File: doc/BRIEF.md
# Outstanding-Request Watchdog

This block watches a class of high-priority management send requests while they are in flight. Each request that goes out is reported by a one-cycle enqueue strobe, and each request that completes is reported by a one-cycle dequeue strobe. The block keeps a saturating count of the requests still outstanding and a deadline timer that covers them. A flush strobe signals an abort or shutdown, in which every outstanding request is dropped at once.

The timer does not run freely. It starts only when the count leaves zero. Further sends do not move the deadline. Each completion that leaves work pending restarts the timer for a full interval, and the last completion stops it. If the interval runs out while requests are still outstanding, the block emits a single-cycle cancel pulse for the surrounding send logic to act on. The interval length is taken from an input at the moment the timer is armed. A value of zero selects a built-in nominal interval of one twentieth of a base tick rate, rounded up. A dequeue that arrives with nothing outstanding is dropped and latched as a sticky error.

Top module: `owd_watchdog`

## Requirements
- R1: After reset, count_o is 0 and timer_running_o, cancel_o and underflow_o are all 0.
- R2: An enqueue that takes the count from 0 to 1 arms the timer with an interval L equal to timeout_cycles_i. If no other event occurs, cancel_o is 1 in the cycle that follows the L-th rising edge after the edge that accepted that enqueue. timer_running_o is 1 from the arming edge up to that point.
- R3: An enqueue while the count is non-zero adds one to the count and leaves the pending deadline unchanged.
- R4: A dequeue that leaves the count non-zero subtracts one and restarts the timer, so the deadline becomes L edges after that dequeue's edge.
- R5: A dequeue that brings the count to 0 stops the timer. No cancel pulse follows, and timer_running_o is 0 whenever count_o is 0.
- R6: A flush sets the count to 0 and stops the timer at the same edge. This takes priority over any enqueue or dequeue in that cycle.
- R7: An enqueue and a dequeue in the same cycle leave the count unchanged. If the count is non-zero, the timer restarts with a full interval. If the count is zero, the timer stays idle and no error is flagged.
- R8: A dequeue alone while the count is 0 leaves the count at 0 and sets underflow_o. underflow_o then stays 1 until reset.
- R9: cancel_o is a single-cycle pulse, raised only while the count is non-zero. After it fires the timer is idle, the count is unchanged, and only a later arm or restart can produce another pulse.
- R10: When timeout_cycles_i is 0 at the arming edge, the interval is (TICK_HZ + 19) / 20 cycles.
- R11: An enqueue alone at the largest count value (all ones in CNT_W bits) leaves the count there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_i | input | 1 | One request of the watched class has been sent |
| deq_i | input | 1 | One outstanding request has completed |
| flush_i | input | 1 | Drop every outstanding request (abort or shutdown) |
| timeout_cycles_i | input | TMR_W | Interval in cycles, sampled when the timer is armed; 0 selects the nominal interval |
| count_o | output | CNT_W | Number of requests outstanding |
| timer_running_o | output | 1 | Deadline timer is counting |
| cancel_o | output | 1 | One-cycle pulse: the deadline passed with work outstanding |
| underflow_o | output | 1 | Sticky: a dequeue arrived with nothing outstanding |

## Verification
The bench builds the block with CNT_W = 3, TMR_W = 8 and TICK_HZ = 200. With these values saturation at a count of 7 is reached after a handful of enqueues, and the nominal interval is 10 cycles, so expiry through a zero timeout input can be watched end to end. Explicit intervals of 1, 5 and 6 cycles are used to place dequeues, paired strobes and flushes on and just before the expiry edge. The short intervals keep every deadline within a few dozen cycles.

// File: rtl/owd_pkg.sv
package owd_pkg;

    // Command the counter issues to the timer for the current cycle
    typedef enum logic [1:0] {
        CMD_TICK = 2'd0,
        CMD_ARM  = 2'd1,
        CMD_STOP = 2'd2
    } owd_cmd_e;

endpackage

// File: rtl/owd_counter.sv
module owd_counter
    import owd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_i,
    input  logic             deq_i,
    input  logic             flush_i,
    output logic [CNT_W-1:0] count_o,
    output logic             nonzero_o,
    output logic             underflow_o,
    output owd_cmd_e         cmd_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             underflow;
    } cnt_s;

    cnt_s     st_d, st_q;
    owd_cmd_e cmd_d;

    always_comb begin
        st_d  = st_q;
        cmd_d = CMD_TICK;
        if (flush_i) begin
            st_d.count = '0;
            cmd_d      = CMD_STOP;
        end else begin
            unique case ({enq_i, deq_i})
                2'b11: begin
                    if (st_q.count != '0) cmd_d = CMD_ARM;
                end
                2'b10: begin
                    if (st_q.count == '0) begin
                        st_d.count = CNT_ONE;
                        cmd_d      = CMD_ARM;
                    end else if (st_q.count != CNT_MAX) begin
                        st_d.count = st_q.count + CNT_ONE;
                    end
                end
                2'b01: begin
                    if (st_q.count == '0) begin
                        st_d.underflow = 1'b1;
                    end else begin
                        st_d.count = st_q.count - CNT_ONE;
                        cmd_d      = (st_q.count == CNT_ONE) ? CMD_STOP : CMD_ARM;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o     = st_q.count;
    assign nonzero_o   = (st_q.count != '0);
    assign underflow_o = st_q.underflow;
    assign cmd_o       = cmd_d;

    p_deq_empty_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_i && !enq_i && !flush_i && st_q.count == '0) |=> (st_q.count == '0 && st_q.underflow));

    p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.underflow |=> st_q.underflow);

    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.count == '0));

    p_pair_holds_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_i && deq_i && !flush_i) |=> $stable(st_q.count));

    p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_i && !deq_i && !flush_i && st_q.count == CNT_MAX) |=> (st_q.count == CNT_MAX));

endmodule

// File: rtl/owd_interval.sv
module owd_interval #(
    parameter int TMR_W   = 16,
    parameter int TICK_HZ = 1000
) (
    input  logic [TMR_W-1:0] cfg_i,
    output logic [TMR_W-1:0] load_o
);

    // Nominal interval: one twentieth of the tick rate, rounded up
    localparam int               NOMINAL = (TICK_HZ + 19) / 20;
    localparam logic [TMR_W-1:0] NOM_V   = TMR_W'(NOMINAL);

    assign load_o = (cfg_i == '0) ? NOM_V : cfg_i;

endmodule

// File: rtl/owd_timer.sv
module owd_timer
    import owd_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  owd_cmd_e         cmd_i,
    input  logic [TMR_W-1:0] load_i,
    input  logic             work_pending_i,
    output logic             running_o,
    output logic             cancel_o
);

    localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

    typedef struct packed {
        logic [TMR_W-1:0] remaining;
        logic             running;
        logic             cancel;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.cancel = 1'b0;
        unique case (cmd_i)
            CMD_STOP: begin
                st_d.running = 1'b0;
            end
            CMD_ARM: begin
                st_d.running   = 1'b1;
                st_d.remaining = load_i;
            end
            default: begin
                if (st_q.running) begin
                    if (st_q.remaining <= TMR_ONE) begin
                        st_d.running = 1'b0;
                        st_d.cancel  = work_pending_i;
                    end else begin
                        st_d.remaining = st_q.remaining - TMR_ONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running_o = st_q.running;
    assign cancel_o  = st_q.cancel;

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cancel |=> !st_q.cancel);

    p_idle_after_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cancel |-> !st_q.running);

    p_stop_no_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_STOP) |=> (!st_q.running && !st_q.cancel));

    p_arm_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ARM) |=> (st_q.running && !st_q.cancel));

endmodule

// File: rtl/owd_watchdog.sv
module owd_watchdog
    import owd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int TMR_W   = 16,
    parameter int TICK_HZ = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_i,
    input  logic             deq_i,
    input  logic             flush_i,
    input  logic [TMR_W-1:0] timeout_cycles_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timer_running_o,
    output logic             cancel_o,
    output logic             underflow_o
);

    owd_cmd_e         cmd;
    logic             nonzero;
    logic [TMR_W-1:0] load;

    owd_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_i      (enq_i),
        .deq_i      (deq_i),
        .flush_i    (flush_i),
        .count_o    (count_o),
        .nonzero_o  (nonzero),
        .underflow_o(underflow_o),
        .cmd_o      (cmd)
    );

    owd_interval #(.TMR_W(TMR_W), .TICK_HZ(TICK_HZ)) u_interval (
        .cfg_i (timeout_cycles_i),
        .load_o(load)
    );

    owd_timer #(.TMR_W(TMR_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd),
        .load_i        (load),
        .work_pending_i(nonzero),
        .running_o     (timer_running_o),
        .cancel_o      (cancel_o)
    );

    p_empty_means_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0) |-> !timer_running_o);

    p_fire_needs_work_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> (count_o != '0));

    p_flush_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!timer_running_o && !cancel_o));

endmodule

// File: tb/tb_owd_watchdog.sv
module tb_owd_watchdog;

    localparam int CNT_W   = 3;
    localparam int TMR_W   = 8;
    localparam int TICK_HZ = 200;
    localparam int NOM     = 10;
    localparam int CMAX    = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enq = 1'b0, deq = 1'b0, flush = 1'b0;
    logic [TMR_W-1:0] cfg = '0;
    logic [CNT_W-1:0] count;
    logic             running, cancel, uflow;

    always #10 clk = ~clk;

    owd_watchdog #(.CNT_W(CNT_W), .TMR_W(TMR_W), .TICK_HZ(TICK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .enq_i(enq), .deq_i(deq), .flush_i(flush),
        .timeout_cycles_i(cfg), .count_o(count), .timer_running_o(running),
        .cancel_o(cancel), .underflow_o(uflow)
    );

    typedef struct {
        int    cnt;
        bit    run;
        bit    cxl;
        bit    uf;
        string tag;
    } exp_t;

    exp_t q[$];
    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;

    // Specification model state
    int m_cnt = 0, m_rem = 0;
    bit m_run = 0, m_uf = 0, m_cxl = 0;

    task automatic model(input bit e, input bit d, input bit f, input int l);
        bit arm  = 0;
        bit stop = 0;
        m_cxl = 0;
        if (f) begin
            m_cnt = 0; stop = 1;
        end else if (e && d) begin
            if (m_cnt > 0) arm = 1;
        end else if (e) begin
            if (m_cnt == 0) begin m_cnt = 1; arm = 1; end
            else if (m_cnt < CMAX) m_cnt++;
        end else if (d) begin
            if (m_cnt == 0) m_uf = 1;
            else begin
                m_cnt--;
                if (m_cnt == 0) stop = 1; else arm = 1;
            end
        end
        if (stop) m_run = 0;
        else if (arm) begin m_run = 1; m_rem = l; end
        else if (m_run) begin
            if (m_rem <= 1) begin m_run = 0; m_cxl = 1; end
            else m_rem--;
        end
    endtask

    // Driver: apply one cycle of stimulus, push the expected outputs
    task automatic step(input bit e, input bit d, input bit f, input string tag);
        exp_t x;
        @(negedge clk);
        enq = e; deq = d; flush = f;
        @(posedge clk);
        model(e, d, f, (cfg == 0) ? NOM : int'(cfg));
        x.cnt = m_cnt; x.run = m_run; x.cxl = m_cxl; x.uf = m_uf; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, tag);
    endtask

    // Monitor: compare outputs away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            tests++;
            if (int'(count) != x.cnt) begin
                fails++;
                $display("FAIL %s count actual=%0d expected=%0d", x.tag, count, x.cnt);
            end
            if (running != x.run) begin
                fails++;
                $display("FAIL %s running actual=%0b expected=%0b", x.tag, running, x.run);
            end
            if (cancel != x.cxl) begin
                fails++;
                $display("FAIL %s cancel actual=%0b expected=%0b", x.tag, cancel, x.cxl);
            end
            if (uflow != x.uf) begin
                fails++;
                $display("FAIL %s underflow actual=%0b expected=%0b", x.tag, uflow, x.uf);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (count != 0 || running || cancel || uflow) begin
            fails++;
            $display("FAIL R1 reset state actual=%0d/%0b/%0b/%0b expected=0/0/0/0",
                     count, running, cancel, uflow);
        end
        rst_n = 1'b1;
        idle(2, "R1");

        // R2: arm from empty, expire after 5 edges
        cfg = 8'd5;
        step(1, 0, 0, "R2");
        idle(7, "R2");
        // R9: idle after firing, count kept; then empty it
        idle(3, "R9");
        step(0, 1, 0, "R5");

        // R2 boundary: interval of 1
        cfg = 8'd1;
        step(1, 0, 0, "R2");
        idle(3, "R2");
        step(0, 1, 0, "R5");

        // R3: later enqueue does not move the deadline
        cfg = 8'd6;
        step(1, 0, 0, "R3");
        idle(2, "R3");
        step(1, 0, 0, "R3");
        idle(5, "R3");
        // R4: dequeue leaving one rearms from idle
        step(0, 1, 0, "R4");
        idle(8, "R4");
        step(1, 0, 0, "R4");
        idle(3, "R4");
        step(0, 1, 0, "R4");
        idle(4, "R4");
        step(0, 1, 0, "R4");
        idle(7, "R4");

        // R5: last completion before expiry, and on the expiry edge
        step(0, 1, 0, "R5");
        step(1, 0, 0, "R5");
        idle(2, "R5");
        step(0, 1, 0, "R5");
        idle(8, "R5");
        step(1, 0, 0, "R5");
        idle(5, "R5");
        step(0, 1, 0, "R5");
        idle(3, "R5");

        // R7: paired strobes
        step(1, 1, 0, "R7");
        idle(2, "R7");
        step(1, 0, 0, "R7");
        idle(3, "R7");
        step(1, 1, 0, "R7");
        idle(8, "R7");

        // R6: flush with competing enqueue, and flush on expiry edge
        step(1, 0, 0, "R6");
        step(1, 0, 0, "R6");
        step(1, 1, 1, "R6");
        idle(8, "R6");
        step(1, 0, 0, "R6");
        idle(5, "R6");
        step(0, 0, 1, "R6");
        idle(3, "R6");

        // R10: nominal interval when configured to zero
        cfg = 8'd0;
        step(1, 0, 0, "R10");
        idle(12, "R10");
        step(0, 0, 1, "R10");

        // R11: saturation
        cfg = 8'd40;
        for (int i = 0; i < 9; i++) step(1, 0, 0, "R11");
        step(0, 1, 0, "R11");
        step(0, 0, 1, "R11");

        // R8: underflow ignored and sticky
        step(0, 1, 0, "R8");
        step(0, 1, 0, "R8");
        step(1, 0, 0, "R8");
        step(0, 0, 1, "R8");
        idle(2, "R8");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule